// File: doc/BRIEF.md
# Selectable Serial Shift-Clock Generator

This block makes the bit clock for a synchronous serial shifter. In master mode it takes one of eight candidate clock sources and divides it by a power of two from 1 to 128. It drives the result onto the serial clock pin, with the idle level set by a polarity bit. In slave mode it ignores the source and divider settings and follows the clock that arrives on the external pin. In both modes it emits single-cycle shift and sample strobes. The shifter uses these strobes to launch and to capture data. A phase bit decides which clock edge carries which strobe.

Every source is treated as a level waveform and sampled in the system clock domain. The external pin passes through a synchronizer first. Both rising and falling transitions of the chosen source count as source edges. The generator halts while either of two pending-flag inputs is high: the word-complete flag or the start-condition flag. While halted, the clock rests at its idle level, the divider is cleared and no strobe is issued. After release, the next output edge is again a leading edge.

Top module: `serclk_gen`

## Requirements
- R1: In master mode, with divide code d on `cfg_div` (0 to 7), the output clock makes one transition for every 2^d transitions of the selected source. After a halt, the first output transition comes on the 2^d-th source transition.
- R2: In master mode, `cfg_src` selects the source. Code 0 is the external pin, 1 is internal clock A, 2 and 3 are both internal clock B, 4 is the software clock bit, and 5, 6 and 7 are timer compare outputs 0, 1 and 2. Transitions on unselected sources have no effect.
- R3: In slave mode (`cfg_master` = 0), only transitions of the external pin advance the clock. Every such transition yields one strobe, whatever the values of `cfg_src` and `cfg_div`.
- R4: `sclk_oe` is 1 in master mode and 0 in slave mode.
- R5: While idle, `sclk_out` equals `cfg_pol`: 0 means the clock idles low and 1 means it idles high. Each output transition inverts the level, and out of reset the output is at the idle level.
- R6: With `cfg_pha` = 0, a leading edge (idle to active) carries `shift_stb` and a trailing edge carries `sample_stb`. With `cfg_pha` = 1, the assignment is the other way round.
- R7: While `cnt_done_flag` or `start_flag` is high, no strobe is issued and `sclk_out` returns to the idle level in the next cycle. Source transitions in that time are dropped, and so is a transition processed in the same cycle as the halt. After release, the next output edge is a leading edge.
- R8: Every output transition carries exactly one strobe, and the two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_clk_a | input | 1 | Internal clock source A (level waveform) |
| int_clk_b | input | 1 | Internal clock source B (level waveform) |
| ext_sclk_in | input | 1 | External serial clock pin, asynchronous |
| soft_clk_bit | input | 1 | Software-driven clock level |
| tmr_cmp_out | input | 3 | Timer compare outputs 0..2 |
| cfg_src | input | 3 | Source select code (R2) |
| cfg_div | input | 3 | Power-of-two divide code |
| cfg_pol | input | 1 | Idle clock level |
| cfg_pha | input | 1 | Strobe-to-edge assignment |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cnt_done_flag | input | 1 | Word-complete flag, halts the clock |
| start_flag | input | 1 | Start-condition flag, halts the clock |
| sclk_out | output | 1 | Serial clock level to drive on the pin |
| sclk_oe | output | 1 | Pin drive enable |
| shift_stb | output | 1 | One-cycle data launch strobe |
| sample_stb | output | 1 | One-cycle data capture strobe |

## Verification
The halt request and a divided source edge can land in the same system cycle. When that happens, the halt must win: the edge is dropped without a strobe and without a late strobe after release. The bench provokes this by toggling the software clock bit and raising the word-complete flag one cycle later, so that the flag is high on the exact edge where the toggle would be turned into an output transition. It then expects zero strobes, the idle level on the pin, and a leading-edge shift strobe for the first toggle after release.

// File: rtl/serclk_pkg.sv
package serclk_pkg;

   localparam int SRC_CODE_W = 3;
   localparam int NUM_SRC    = 1 << SRC_CODE_W;
   localparam int NUM_TMR    = 3;

   typedef enum logic [SRC_CODE_W-1:0] {
      SRC_EXT_PIN = 3'd0,
      SRC_INT_A   = 3'd1,
      SRC_INT_B   = 3'd2,
      SRC_INT_B2  = 3'd3,
      SRC_SOFT    = 3'd4,
      SRC_TMR0    = 3'd5,
      SRC_TMR1    = 3'd6,
      SRC_TMR2    = 3'd7
   } src_sel_e;

   typedef struct packed {
      logic shift;
      logic sample;
   } strobe_t;

endpackage

// File: rtl/serclk_src_sample.sv
module serclk_src_sample #(
   parameter int NUM_SRC     = 8,
   parameter int EXT_IDX     = 0,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] raw_i,
   output logic [NUM_SRC-1:0] level_o,
   output logic [NUM_SRC-1:0] edge_o
);

   localparam int ARM_LAST = SYNC_STAGES + 1;
   localparam int ARM_W    = $clog2(ARM_LAST + 1);

   logic [NUM_SRC-1:0] prev_q;
   logic [ARM_W-1:0]   arm_cnt_q;
   logic               armed;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (i == EXT_IDX) begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q <= '0;
               else        chain_q <= raw_i[i];
            end
         end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q <= '0;
               else        chain_q <= {chain_q[SYNC_STAGES-2:0], raw_i[i]};
            end
         end
         assign level_o[i] = chain_q[SYNC_STAGES-1];
      end else begin : g_plain
         logic smp_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) smp_q <= 1'b0;
            else        smp_q <= raw_i[i];
         end
         assign level_o[i] = smp_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level_o;
   end

   // edges are ignored until every sampling stage holds real pin data
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         arm_cnt_q <= '0;
      else if (arm_cnt_q != ARM_W'(ARM_LAST)) arm_cnt_q <= arm_cnt_q + 1'b1;
   end

   assign armed  = (arm_cnt_q == ARM_W'(ARM_LAST));
   assign edge_o = (level_o ^ prev_q) & {NUM_SRC{armed}};

endmodule

// File: rtl/serclk_div.sv
module serclk_div #(
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              tick_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              tick_o
);

   localparam int CNT_W = (1 << CODE_W) - 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   span;
   logic [CNT_W-1:0] limit;
   logic             at_limit;

   assign span     = (CNT_W+1)'(1) << code_i;
   assign limit    = CNT_W'(span - 1'b1);
   assign at_limit = (cnt_q >= limit);
   assign tick_o   = tick_i & at_limit & ~clear_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (clear_i)  cnt_q <= '0;
      else if (tick_i)   cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
   end

endmodule

// File: rtl/serclk_phase.sv
module serclk_phase
   import serclk_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    tick_i,
   input  logic    halt_i,
   input  logic    master_i,
   input  logic    ext_active_i,
   input  logic    pha_i,
   output logic    active_o,
   output strobe_t stb_o
);

   logic active_q;
   logic nxt_active;
   logic moves;
   logic go;

   always_comb begin
      nxt_active = master_i ? ~active_q : ext_active_i;
      moves      = master_i | (ext_active_i != active_q);
      go         = tick_i & moves & ~halt_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         stb_o    <= '0;
      end else if (halt_i) begin
         active_q <= 1'b0;
         stb_o    <= '0;
      end else if (go) begin
         active_q     <= nxt_active;
         stb_o.shift  <= nxt_active ^ pha_i;
         stb_o.sample <= ~(nxt_active ^ pha_i);
      end else begin
         stb_o <= '0;
      end
   end

   assign active_o = active_q;

endmodule

// File: rtl/serclk_gen.sv
module serclk_gen
   import serclk_pkg::*;
#(
   parameter int DIV_CODE_W  = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  int_clk_a,
   input  logic                  int_clk_b,
   input  logic                  ext_sclk_in,
   input  logic                  soft_clk_bit,
   input  logic [NUM_TMR-1:0]    tmr_cmp_out,
   input  logic [SRC_CODE_W-1:0] cfg_src,
   input  logic [DIV_CODE_W-1:0] cfg_div,
   input  logic                  cfg_pol,
   input  logic                  cfg_pha,
   input  logic                  cfg_master,
   input  logic                  cnt_done_flag,
   input  logic                  start_flag,
   output logic                  sclk_out,
   output logic                  sclk_oe,
   output logic                  shift_stb,
   output logic                  sample_stb
);

   localparam int EXT_IDX = int'(SRC_EXT_PIN);

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("serclk_gen: SYNC_STAGES must be at least 1");
   end
   if (DIV_CODE_W < 1 || DIV_CODE_W > 4) begin : g_bad_div
      $error("serclk_gen: DIV_CODE_W must lie in 1..4");
   end

   logic [NUM_SRC-1:0]    raw_src;
   logic [NUM_SRC-1:0]    src_level;
   logic [NUM_SRC-1:0]    src_edge;
   src_sel_e              sel_eff;
   logic [DIV_CODE_W-1:0] div_eff;
   logic                  halt;
   logic                  sel_edge;
   logic                  div_tick;
   logic                  active;
   strobe_t               stb;

   always_comb begin
      raw_src                  = '0;
      raw_src[SRC_EXT_PIN]     = ext_sclk_in;
      raw_src[SRC_INT_A]       = int_clk_a;
      raw_src[SRC_INT_B]       = int_clk_b;
      raw_src[SRC_INT_B2]      = int_clk_b;
      raw_src[SRC_SOFT]        = soft_clk_bit;
      raw_src[SRC_TMR0]        = tmr_cmp_out[0];
      raw_src[SRC_TMR1]        = tmr_cmp_out[1];
      raw_src[SRC_TMR2]        = tmr_cmp_out[2];
   end

   serclk_src_sample #(
      .NUM_SRC     (NUM_SRC),
      .EXT_IDX     (EXT_IDX),
      .SYNC_STAGES (SYNC_STAGES)
   ) i_sample (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_i   (raw_src),
      .level_o (src_level),
      .edge_o  (src_edge)
   );

   // a slave follows the pin one edge at a time
   assign sel_eff  = cfg_master ? src_sel_e'(cfg_src) : SRC_EXT_PIN;
   assign div_eff  = cfg_master ? cfg_div : '0;
   assign sel_edge = src_edge[sel_eff];
   assign halt     = cnt_done_flag | start_flag;

   serclk_div #(
      .CODE_W (DIV_CODE_W)
   ) i_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (halt),
      .tick_i  (sel_edge),
      .code_i  (div_eff),
      .tick_o  (div_tick)
   );

   serclk_phase i_phase (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_i       (div_tick),
      .halt_i       (halt),
      .master_i     (cfg_master),
      .ext_active_i (src_level[EXT_IDX] ^ cfg_pol),
      .pha_i        (cfg_pha),
      .active_o     (active),
      .stb_o        (stb)
   );

   assign sclk_out   = active ^ cfg_pol;
   assign sclk_oe    = cfg_master;
   assign shift_stb  = stb.shift;
   assign sample_stb = stb.sample;

endmodule

// File: rtl/serclk_gen_chk.sv
module serclk_gen_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_master,
   input logic cfg_pol,
   input logic cfg_pha,
   input logic cnt_done_flag,
   input logic start_flag,
   input logic sclk_out,
   input logic shift_stb,
   input logic sample_stb
);

   // R8: strobes are mutually exclusive
   p_stb_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({shift_stb, sample_stb}));

   // R7: a pending flag blocks every strobe
   p_halt_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_done_flag || start_flag) |=> !(shift_stb || sample_stb));

   // R7: a pending flag parks the clock at its idle level
   p_halt_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_done_flag || start_flag) |=> (sclk_out == cfg_pol));

   // R6: launch strobe with phase 0 sits on a leading edge
   p_lead_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_master && shift_stb && !cfg_pha && $stable(cfg_pha) && $stable(cfg_pol)
       && $stable(cfg_master)) |-> (sclk_out != cfg_pol));

   // R6: capture strobe with phase 0 sits on a trailing edge
   p_trail_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_master && sample_stb && !cfg_pha && $stable(cfg_pha) && $stable(cfg_pol)
       && $stable(cfg_master)) |-> (sclk_out == cfg_pol));

endmodule

bind serclk_gen serclk_gen_chk i_serclk_gen_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_master    (cfg_master),
   .cfg_pol       (cfg_pol),
   .cfg_pha       (cfg_pha),
   .cnt_done_flag (cnt_done_flag),
   .start_flag    (start_flag),
   .sclk_out      (sclk_out),
   .shift_stb     (shift_stb),
   .sample_stb    (sample_stb)
);

// File: tb/test_serclk_gen.sv
`timescale 1ns/1ps
module test_serclk_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       int_clk_a = 1'b0;
   logic       int_clk_b = 1'b0;
   logic       ext_sclk_in = 1'b0;
   logic       soft_clk_bit = 1'b0;
   logic [2:0] tmr_cmp_out = '0;
   logic [2:0] cfg_src = 3'd4;
   logic [2:0] cfg_div = 3'd0;
   logic       cfg_pol = 1'b0;
   logic       cfg_pha = 1'b0;
   logic       cfg_master = 1'b1;
   logic       cnt_done_flag = 1'b0;
   logic       start_flag = 1'b0;
   logic       sclk_out;
   logic       sclk_oe;
   logic       shift_stb;
   logic       sample_stb;

   int n_checks = 0;
   int n_errors = 0;
   int n_shift  = 0;
   int n_sample = 0;
   int n_trans  = 0;
   logic last_out = 1'b0;
   bit   finished = 1'b0;

   always #2.5 clk = ~clk;

   serclk_gen i_serclk_gen (
      .clk           (clk),
      .rst_n         (rst_n),
      .int_clk_a     (int_clk_a),
      .int_clk_b     (int_clk_b),
      .ext_sclk_in   (ext_sclk_in),
      .soft_clk_bit  (soft_clk_bit),
      .tmr_cmp_out   (tmr_cmp_out),
      .cfg_src       (cfg_src),
      .cfg_div       (cfg_div),
      .cfg_pol       (cfg_pol),
      .cfg_pha       (cfg_pha),
      .cfg_master    (cfg_master),
      .cnt_done_flag (cnt_done_flag),
      .start_flag    (start_flag),
      .sclk_out      (sclk_out),
      .sclk_oe       (sclk_oe),
      .shift_stb     (shift_stb),
      .sample_stb    (sample_stb)
   );

   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         if (shift_stb)  n_shift++;
         if (sample_stb) n_sample++;
         if (sclk_out !== last_out) n_trans++;
      end
      last_out = sclk_out;
   end

   task automatic check(input string tag, input bit ok, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic zero_counts();
      @(negedge clk);
      n_shift = 0; n_sample = 0; n_trans = 0;
   endtask

   task automatic flip(input int code);
      case (code)
         0: ext_sclk_in = ~ext_sclk_in;
         1: int_clk_a = ~int_clk_a;
         2, 3: int_clk_b = ~int_clk_b;
         4: soft_clk_bit = ~soft_clk_bit;
         default: tmr_cmp_out[code-5] = ~tmr_cmp_out[code-5];
      endcase
   endtask

   task automatic toggle_src(input int code, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         flip(code);
         @(negedge clk);
      end
      repeat (8) @(negedge clk);
   endtask

   task automatic restart();
      @(negedge clk);
      cnt_done_flag = 1'b1;
      @(negedge clk);
      cnt_done_flag = 1'b0;
      repeat (2) @(negedge clk);
      zero_counts();
   endtask

   task automatic t_reset();
      #1;
      check("R5 reset idle level", sclk_out == 1'b0, sclk_out, 0);
      check("R8 no strobe in reset", {shift_stb, sample_stb} == 2'b00, {shift_stb, sample_stb}, 0);
      check("R4 master drives pin", sclk_oe == 1'b1, sclk_oe, 1);
   endtask

   task automatic t_divide();
      int codes [4] = '{0, 1, 3, 7};
      int edges [4] = '{16, 16, 16, 256};
      cfg_master = 1; cfg_src = 3'd4; cfg_pol = 0; cfg_pha = 0;
      for (int k = 0; k < 4; k++) begin
         cfg_div = 3'(codes[k]);
         restart();
         toggle_src(4, edges[k]);
         check("R1 divide ratio", n_trans == edges[k] >> codes[k], n_trans, edges[k] >> codes[k]);
         check("R8 one strobe per transition", n_shift + n_sample == n_trans, n_shift + n_sample, n_trans);
      end
      cfg_div = 3'd2;
      restart();
      toggle_src(4, 3);
      check("R1 no output before 2^d source edges", n_trans == 0, n_trans, 0);
      toggle_src(4, 1);
      check("R1 first output on 2^d-th edge", n_trans == 1, n_trans, 1);
      cfg_div = 3'd0;
   endtask

   task automatic t_source_map();
      cfg_master = 1; cfg_div = 0; cfg_pol = 0; cfg_pha = 0;
      for (int c = 0; c < 8; c++) begin
         cfg_src = 3'(c);
         restart();
         toggle_src(c, 4);
         check("R2 selected source drives clock", n_trans == 4, n_trans, 4);
         zero_counts();
         toggle_src((c + 4) % 8, 4);
         check("R2 unselected source ignored", n_trans == 0, n_trans, 0);
      end
      cfg_src = 3'd4;
   endtask

   task automatic t_phase();
      cfg_master = 1; cfg_src = 3'd4; cfg_div = 0; cfg_pol = 0;
      for (int p = 0; p < 2; p++) begin
         cfg_pha = p[0];
         restart();
         toggle_src(4, 1);
         check("R6 leading edge strobe shift", n_shift == (p == 0 ? 1 : 0), n_shift, p == 0 ? 1 : 0);
         check("R6 leading edge strobe sample", n_sample == (p == 0 ? 0 : 1), n_sample, p == 0 ? 0 : 1);
         toggle_src(4, 1);
         check("R6 trailing edge adds other strobe", n_shift == 1 && n_sample == 1, n_shift * 10 + n_sample, 11);
      end
      cfg_pha = 0;
   endtask

   task automatic t_polarity();
      cfg_master = 1; cfg_src = 3'd4; cfg_div = 0; cfg_pha = 0;
      cfg_pol = 1;
      restart();
      check("R5 idle high", sclk_out == 1'b1, sclk_out, 1);
      toggle_src(4, 1);
      check("R5 active low after leading edge", sclk_out == 1'b0, sclk_out, 0);
      toggle_src(4, 1);
      check("R5 back to idle high", sclk_out == 1'b1, sclk_out, 1);
      cfg_pol = 0;
      restart();
   endtask

   task automatic t_halt();
      cfg_master = 1; cfg_src = 3'd4; cfg_div = 0; cfg_pol = 0; cfg_pha = 0;
      restart();
      toggle_src(4, 1);
      check("R7 active before halt", sclk_out == 1'b1, sclk_out, 1);
      @(negedge clk);
      cnt_done_flag = 1'b1;
      repeat (2) @(negedge clk);
      check("R7 done flag returns idle", sclk_out == 1'b0, sclk_out, 0);
      zero_counts();
      toggle_src(4, 4);
      check("R7 no strobe while done flag", n_shift + n_sample == 0, n_shift + n_sample, 0);
      check("R7 held idle", sclk_out == 1'b0, sclk_out, 0);
      @(negedge clk);
      cnt_done_flag = 1'b0;
      zero_counts();
      toggle_src(4, 1);
      check("R7 resumes on leading edge", n_shift == 1 && sclk_out == 1'b1, n_shift, 1);
      restart();
      start_flag = 1'b1;
      toggle_src(4, 4);
      check("R7 no strobe while start flag", n_shift + n_sample == 0, n_shift + n_sample, 0);
      start_flag = 1'b0;
      restart();
      // source edge and halt meet in one cycle
      @(negedge clk);
      flip(4);
      @(negedge clk);
      cnt_done_flag = 1'b1;
      @(negedge clk);
      cnt_done_flag = 1'b0;
      repeat (6) @(negedge clk);
      check("R7 colliding edge dropped", n_shift + n_sample == 0, n_shift + n_sample, 0);
      check("R7 colliding edge keeps idle", sclk_out == 1'b0, sclk_out, 0);
      zero_counts();
      toggle_src(4, 1);
      check("R7 after collision leading shift", n_shift == 1 && n_sample == 0, n_shift, 1);
      restart();
   endtask

   task automatic t_slave();
      cfg_master = 0; cfg_src = 3'd4; cfg_div = 3'd3; cfg_pol = 0; cfg_pha = 0;
      repeat (2) @(negedge clk);
      check("R4 slave releases pin", sclk_oe == 1'b0, sclk_oe, 0);
      restart();
      toggle_src(4, 4);
      check("R3 slave ignores source select", n_shift + n_sample == 0, n_shift + n_sample, 0);
      toggle_src(0, 6);
      check("R3 slave shift per pin edge", n_shift == 3, n_shift, 3);
      check("R3 slave sample per pin edge", n_sample == 3, n_sample, 3);
      cfg_master = 1; cfg_div = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      repeat (6) @(negedge clk);
      t_divide();
      t_source_map();
      t_phase();
      t_polarity();
      t_halt();
      t_slave();
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      #(5.0 * 200000);
      if (!finished) begin
         finished = 1'b1;
         check("watchdog expired", 1'b0, 0, 1);
         $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

endmodule